// File: doc/BRIEF.md
# Logarithm Special-Operand Handler

This block sits beside the arithmetic path of a pipelined floating-point logarithm unit. Each cycle it can accept one IEEE-754 operand, qualified by an input strobe. It sorts the operand into one of four classes. Three of these classes have a fixed logarithm: NaN, plus infinity and minus infinity. The fourth class holds the positive finite values, which need the real approximation.

The class travels down a delay line whose length matches the latency of the arithmetic path. At the last stage a registered two-to-one selection either emits the fixed replacement value or passes the approximation word that the arithmetic path delivers in that cycle. An output strobe marks each result. The same strobe and classification stay in step for any pipeline depth and for any exponent and fraction width.

Top module: `log_special_path`

## Requirements
- R1: An operand with the sign bit set whose remaining bits are not all zero yields the quiet NaN pattern: sign 0, exponent field all ones, fraction MSB 1 and other fraction bits 0. This covers minus infinity, negative normals and negative subnormals. `out_special` is 1 for such a result.
- R2: An operand whose exponent field is all ones and whose fraction is nonzero, of either sign, yields the same quiet NaN pattern with `out_special` = 1.
- R3: Plus infinity (sign 0, exponent all ones, fraction 0) yields plus infinity with `out_special` = 1.
- R4: Plus zero and minus zero (exponent and fraction all zero) yield minus infinity (sign 1, exponent all ones, fraction 0) with `out_special` = 1.
- R5: A positive normal or subnormal operand gives `out_special` = 0. For such an operand, `out_result` equals the `approx_in` word that is present in the cycle DEPTH-1 cycles after the operand was presented.
- R6: An operand with `in_valid` high in cycle n produces `out_valid` high in cycle n+DEPTH, and in no other cycle. Back-to-back operands produce back-to-back results.
- R7: Synchronous reset clears every valid stage. `out_valid` stays low for the first DEPTH cycles after reset, and then stays low until a valid operand has crossed the full depth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand qualifier |
| in_operand | input | 1+EXP_W+MAN_W | IEEE-754 operand |
| approx_in | input | 1+EXP_W+MAN_W | Approximation from the arithmetic path, DEPTH-1 cycles behind the operand |
| out_valid | output | 1 | Result qualifier |
| out_special | output | 1 | Select: 1 = replacement value, 0 = approximation |
| out_result | output | 1+EXP_W+MAN_W | Logarithm result |

## Verification
Uniform random 64-bit words almost never hit a zero, an infinity or a NaN. The stimulus therefore first draws a class and then fills in the fields: random NaN payloads with a forced nonzero fraction, signed zeros, both infinities, subnormals, and negative values with random magnitude. The hardest situation to reach is a reset that lands while the delay line is full. The bench pulses reset in the middle of a stream with valid gaps and then checks the silent window that follows, at the ports. The arithmetic path is modelled as a delayed bit-scramble of the operand. A result that is one cycle misaligned therefore appears as a payload mismatch.

// File: rtl/log_sc_pkg.sv
package log_sc_pkg;
  typedef enum logic [1:0] {
    LC_ARITH = 2'd0,
    LC_QNAN  = 2'd1,
    LC_PINF  = 2'd2,
    LC_NINF  = 2'd3
  } lc_cls_e;
endpackage

// File: rtl/log_sc_classify.sv
module log_sc_classify
  import log_sc_pkg::*;
#(
  parameter int EXP_W = 11,
  parameter int MAN_W = 52
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_valid,
  input  logic [EXP_W+MAN_W:0]   operand,
  output logic                   cls_valid,
  output lc_cls_e                cls_q
);
  localparam int W = 1 + EXP_W + MAN_W;

  logic             sgn;
  logic [EXP_W-1:0] ex;
  logic [MAN_W-1:0] mn;
  logic             exp_ones, exp_zero, man_zero;
  lc_cls_e          cls_d;

  assign sgn      = operand[W-1];
  assign ex       = operand[W-2:MAN_W];
  assign mn       = operand[MAN_W-1:0];
  assign exp_ones = &ex;
  assign exp_zero = (ex == '0);
  assign man_zero = (mn == '0);

  // Priority: NaN, then zero of either sign, then any other negative, then +inf.
  always_comb begin
    if (exp_ones && !man_zero)      cls_d = LC_QNAN;
    else if (exp_zero && man_zero)  cls_d = LC_NINF;
    else if (sgn)                   cls_d = LC_QNAN;
    else if (exp_ones)              cls_d = LC_PINF;
    else                            cls_d = LC_ARITH;
  end

  always_ff @(posedge clk) begin
    if (rst) cls_valid <= 1'b0;
    else     cls_valid <= in_valid;
    cls_q <= cls_d;
  end

  // R1
  neg_to_nan_chk: assert property (@(posedge clk) disable iff (rst)
    (operand[W-1] && operand[W-2:0] != '0) |=> cls_q == LC_QNAN);
  // R4
  zero_to_ninf_chk: assert property (@(posedge clk) disable iff (rst)
    (operand[W-2:0] == '0) |=> cls_q == LC_NINF);
  // R5
  finite_pos_arith_chk: assert property (@(posedge clk) disable iff (rst)
    (!operand[W-1] && operand[W-2:0] != '0 && !(&operand[W-2:MAN_W])) |=> cls_q == LC_ARITH);
endmodule

// File: rtl/log_sc_delay.sv
module log_sc_delay
  import log_sc_pkg::*;
#(
  parameter int STAGES = 20
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    v_i,
  input  lc_cls_e cls_i,
  output logic    v_o,
  output lc_cls_e cls_o
);
  logic    v_q   [STAGES];
  lc_cls_e cls_r [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (rst) v_q[i] <= 1'b0;
        else     v_q[i] <= v_i;
        cls_r[i] <= cls_i;
      end
    end else begin : g_body
      always_ff @(posedge clk) begin
        if (rst) v_q[i] <= 1'b0;
        else     v_q[i] <= v_q[i-1];
        cls_r[i] <= cls_r[i-1];
      end
    end
  end

  assign v_o   = v_q[STAGES-1];
  assign cls_o = cls_r[STAGES-1];

  // R6
  delay_head_follow_chk: assert property (@(posedge clk) disable iff (rst)
    v_i |=> v_q[0]);
endmodule

// File: rtl/log_sc_outmux.sv
module log_sc_outmux
  import log_sc_pkg::*;
#(
  parameter int EXP_W = 11,
  parameter int MAN_W = 52
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 valid_i,
  input  lc_cls_e              cls_i,
  input  logic [EXP_W+MAN_W:0] approx_i,
  output logic                 out_valid,
  output logic                 out_special,
  output logic [EXP_W+MAN_W:0] out_result
);
  localparam int W = 1 + EXP_W + MAN_W;
  localparam logic [W-1:0] QNAN_V = {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};
  localparam logic [W-1:0] PINF_V = {1'b0, {EXP_W{1'b1}}, {MAN_W{1'b0}}};
  localparam logic [W-1:0] NINF_V = {1'b1, {EXP_W{1'b1}}, {MAN_W{1'b0}}};

  logic [W-1:0] repl;

  always_comb begin
    case (cls_i)
      LC_QNAN: repl = QNAN_V;
      LC_PINF: repl = PINF_V;
      LC_NINF: repl = NINF_V;
      default: repl = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_special <= 1'b0;
      out_result  <= '0;
    end else begin
      out_valid   <= valid_i;
      out_special <= (cls_i != LC_ARITH);
      out_result  <= (cls_i != LC_ARITH) ? repl : approx_i;
    end
  end

  // R3
  special_exp_full_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_special) |-> (&out_result[W-2:MAN_W]));
  // R5
  arith_selects_path_chk: assert property (@(posedge clk) disable iff (rst)
    (valid_i && cls_i == LC_ARITH) |=> (out_valid && !out_special));
endmodule

// File: rtl/log_special_path.sv
module log_special_path
  import log_sc_pkg::*;
#(
  parameter int EXP_W = 11,
  parameter int MAN_W = 52,
  parameter int DEPTH = 22
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic [EXP_W+MAN_W:0] in_operand,
  input  logic [EXP_W+MAN_W:0] approx_in,
  output logic                 out_valid,
  output logic                 out_special,
  output logic [EXP_W+MAN_W:0] out_result
);
  localparam int MID   = DEPTH - 2;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic    c_valid, d_valid;
  lc_cls_e c_cls, d_cls;

  log_sc_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls (
    .clk(clk), .rst(rst), .in_valid(in_valid), .operand(in_operand),
    .cls_valid(c_valid), .cls_q(c_cls));

  log_sc_delay #(.STAGES(MID)) u_dly (
    .clk(clk), .rst(rst), .v_i(c_valid), .cls_i(c_cls),
    .v_o(d_valid), .cls_o(d_cls));

  log_sc_outmux #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_mux (
    .clk(clk), .rst(rst), .valid_i(d_valid), .cls_i(d_cls),
    .approx_i(approx_in), .out_valid(out_valid),
    .out_special(out_special), .out_result(out_result));

  // Checker-side count of cycles since reset, saturating at DEPTH.
  logic [CNT_W-1:0] since_rst;
  always_ff @(posedge clk) begin
    if (rst)                              since_rst <= '0;
    else if (since_rst < CNT_W'(DEPTH))   since_rst <= since_rst + 1'b1;
  end

  // R7
  no_early_valid_chk: assert property (@(posedge clk) disable iff (rst)
    (since_rst < CNT_W'(DEPTH)) |-> !out_valid);
  // R6
  stage_one_follow_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> c_valid);
endmodule

// File: tb/log_special_path_test.sv
`timescale 1ns/1ps
module log_special_path_test;
  localparam int DEPTH = 22;
  localparam logic [63:0] QNAN = 64'h7FF8_0000_0000_0000;
  localparam logic [63:0] PINF = 64'h7FF0_0000_0000_0000;
  localparam logic [63:0] NINF = 64'hFFF0_0000_0000_0000;
  localparam logic [63:0] SCR  = 64'h0F0F_3C3C_5A5A_A5A5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [63:0] in_operand = '0;
  logic [63:0] approx_in;
  logic out_valid, out_special;
  logic [63:0] out_result;

  always #2.5 clk = ~clk;

  log_special_path #(.EXP_W(11), .MAN_W(52), .DEPTH(DEPTH)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_operand(in_operand),
    .approx_in(approx_in), .out_valid(out_valid),
    .out_special(out_special), .out_result(out_result));

  // Arithmetic path model: scrambled operand, DEPTH-1 cycles late.
  logic [63:0] hist [DEPTH-1];
  always_ff @(posedge clk) begin
    hist[0] <= in_operand;
    for (int i = 1; i < DEPTH-1; i++) hist[i] <= hist[i-1];
  end
  assign approx_in = hist[DEPTH-2] ^ SCR;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;
  bit          rv [64];
  logic        rs [64];
  logic [63:0] rr [64];
  string       rt [64];

  function automatic void expect_of(input logic [63:0] op, output logic sp,
                                    output logic [63:0] res, output string tag);
    logic ones = &op[62:52];
    logic mz   = (op[51:0] == '0);
    if (ones && !mz)                 begin sp = 1; res = QNAN; tag = "R2"; end
    else if (op[62:0] == '0)         begin sp = 1; res = NINF; tag = "R4"; end
    else if (op[63])                 begin sp = 1; res = QNAN; tag = "R1"; end
    else if (ones)                   begin sp = 1; res = PINF; tag = "R3"; end
    else                             begin sp = 0; res = op ^ SCR; tag = "R5"; end
  endfunction

  task automatic step(input bit v, input logic [63:0] op);
    int ro;
    int wi;
    @(negedge clk);
    ro = (cyc + 64 - DEPTH) % 64;
    checks++;
    if (out_valid !== rv[ro]) begin
      errors++;
      $display("FAIL R6/R7 cycle %0d out_valid actual %b expected %b", cyc, out_valid, rv[ro]);
    end else if (rv[ro]) begin
      checks++;
      if (out_special !== rs[ro] || out_result !== rr[ro]) begin
        errors++;
        $display("FAIL %s cycle %0d actual sel %b res %h expected sel %b res %h",
                 rt[ro], cyc, out_special, out_result, rs[ro], rr[ro]);
      end
    end
    wi = cyc % 64;
    rv[wi] = v && !rst;
    expect_of(op, rs[wi], rr[wi], rt[wi]);
    in_valid = v;
    in_operand = op;
    cyc++;
  endtask

  task automatic clear_ring();
    for (int i = 0; i < 64; i++) rv[i] = 0;
  endtask

  function automatic logic [63:0] rnd64();
    return {$urandom(), $urandom()};
  endfunction

  function automatic logic [63:0] rnd_op();
    logic [63:0] x = rnd64();
    case ($urandom_range(0, 7))
      0, 1, 2: begin x[63] = 0; if (&x[62:52]) x[62] = 0; end       // positive normal
      3: begin x[63] = 0; x[62:52] = '0; if (x[51:0] == '0) x[0] = 1; end // subnormal
      4: begin x[63] = 1; end                                         // negative
      5: begin x[62:52] = '1; if (x[51:0] == '0) x[5] = 1; end        // NaN
      6: begin x[62:0] = {11'h7FF, 52'h0}; end                        // +/- inf
      default: begin x[62:0] = '0; end                                // +/- zero
    endcase
    return x;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    clear_ring();
    rst = 1;
    // R7: outputs quiet through reset
    repeat (3) step(0, '0);
    rst = 0;
    // Directed corners
    step(1, 64'h0000_0000_0000_0000);   // R4 +0
    step(1, 64'h8000_0000_0000_0000);   // R4 -0
    step(1, PINF);                      // R3
    step(1, NINF);                      // R1 -inf
    step(1, 64'h7FF8_0000_0000_0000);   // R2 quiet NaN
    step(1, 64'h7FF0_0000_0000_0001);   // R2 signalling NaN
    step(1, 64'hFFF4_1234_0000_0000);   // R2 negative NaN
    step(1, 64'h0000_0000_0000_0001);   // R5 smallest subnormal
    step(1, 64'h7FEF_FFFF_FFFF_FFFF);   // R5 largest finite
    step(1, 64'h8000_0000_0000_0001);   // R1 negative subnormal
    step(1, 64'h3FF0_0000_0000_0000);   // R5 one
    step(0, PINF);                      // invalid slot, no output
    step(1, 64'hBFF0_0000_0000_0000);   // R1 minus one
    repeat (DEPTH + 2) step(0, '0);
    // Random mixed stream with gaps (R6)
    for (int k = 0; k < 3000; k++) step($urandom_range(0, 9) < 7, rnd_op());
    // Reset with the line full (R7)
    for (int k = 0; k < DEPTH; k++) step(1, rnd_op());
    rst = 1;
    clear_ring();
    repeat (2) step(0, rnd_op());
    rst = 0;
    for (int k = 0; k < DEPTH; k++) step(0, rnd_op());
    for (int k = 0; k < 500; k++) step(1, rnd_op());
    repeat (DEPTH + 2) step(0, '0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule